// File: doc/BRIEF.md
# CCD Frame and Exposure Sequencer

This block is the frame-level controller of a CCD timing chain. It does not draw clock waveforms itself. It asks a separate line sequencer to run one of its stored line tables, waits for the sequencer to report that the table has finished, and then decides which table comes next. One frame runs in this order:

1. a photodiode-to-vertical-register transfer;
2. an exposure interval, counted in millisecond ticks, with `integrate` held high;
3. a fixed number of line transfers that read the frame out, with `frame_valid` high;
4. a flush table, after which the cycle starts again.

Exposure is also trimmed by an electronic shutter pulse. The pulse is issued during readout at a line position chosen by a 3-bit preset. The preset is captured while reset is asserted and is never sampled again. An exposure change therefore needs a reset to take effect.

Top module: `ccd_frame_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `lt_req`, `integrate`, `frame_valid` and `shutter_pulse` are low. The first request after reset carries table code 1 (photodiode transfer).
- R2: Once raised, `lt_req` stays high with `lt_sel` unchanged until a clock edge samples `lt_done` high. After that edge `lt_req` is low for at least one cycle.
- R3: `integrate` rises on the edge that accepts the photodiode transfer. It stays high until the edge that samples the INTEG_TICKS-th `tick_ms` pulse of that interval, and falls on that edge.
- R4: `frame_valid` rises on the edge where `integrate` falls. Readout then issues exactly READOUT_LINES requests with table code 0 (line transfer). `frame_valid` falls on the edge that accepts the last of them, and `integrate` and `frame_valid` are never high together.
- R5: After `frame_valid` falls, exactly one request with table code 5 (flush) is issued. Its acceptance is followed by a new photodiode transfer request, which starts the next frame.
- R6: Preset 0 selects line NO_SHUT_LINE, which lies beyond readout, so no pulse is issued. Preset k in 1..7 selects line SHUT_STEP*(8-k); with the default values these are lines 966, 828, 690, 552, 414, 276 and 138.
- R7: `shutter_pulse` is high exactly while the number of line transfers completed in the current readout equals the selected line. This lasts exactly one line period, from one accepted transfer to the next.
- R8: `preset_sel` is sampled only while `rst` is high. Changes made after reset do not move the shutter line.
- R9: `tick_ms` pulses outside the exposure interval do not advance the exposure count. `lt_done` pulses while `lt_req` is low do not advance the sequence or the line count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also samples the preset |
| preset_sel | input | 3 | Shutter preset index |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| lt_done | input | 1 | Line sequencer reports the requested table finished |
| lt_req | output | 1 | Request to run a line table |
| lt_sel | output | 3 | Table code: 0 line transfer, 1 photodiode transfer, 5 flush |
| integrate | output | 1 | High during the exposure interval |
| frame_valid | output | 1 | High during readout line transfers |
| shutter_pulse | output | 1 | Electronic shutter pulse, one line period long |

## Verification
The bench builds the block with the following parameter values, which keep each frame to a few hundred cycles:

| Parameter | Bench value |
|---|---|
| READOUT_LINES | 20 |
| INTEG_TICKS | 3 |
| SHUT_STEP | 2 |
| NO_SHUT_LINE | 40 |

With these values every shutter preset maps to a line inside readout, and the no-pulse sentinel lies past the last line. Full frames, frame restarts and several resets with different presets all fit in a short run. Stray ticks and done pulses can be dropped into every phase without long waits.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [2:0] {
    ST_DIODE  = 3'd0,
    ST_INTEG  = 3'd1,
    ST_READ   = 3'd2,
    ST_FVWAIT = 3'd3,
    ST_FLUSH  = 3'd4
  } fseq_state_t;

  localparam logic [2:0] TBL_LINE  = 3'd0;
  localparam logic [2:0] TBL_DIODE = 3'd1;
  localparam logic [2:0] TBL_FLUSH = 3'd5;

  // Preset 0 parks the shutter past readout; presets 1..7 step down by step.
  function automatic int unsigned shutter_line_of(input logic [2:0] idx,
                                                  input int unsigned step,
                                                  input int unsigned none_line);
    if (idx == 3'd0) return none_line;
    return step * (32'd8 - 32'(idx));
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fseq_integ_timer.sv
module fseq_integ_timer #(
  parameter int unsigned TICKS = 1,
  parameter int unsigned TW    = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic expire
);
  logic [TW-1:0] count_q;

  assign expire = run && tick && (count_q == TW'(TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) count_q <= '0;
    else if (tick)   count_q <= expire ? '0 : count_q + 1'b1;
  end

  // R3: the tick count never passes the exposure length
  p_tick_bound_r3: assert property (@(posedge clk) disable iff (rst)
    count_q < TW'(TICKS));

  // R9: ticks outside the interval leave the count at zero
  p_idle_ticks_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count_q == '0));
endmodule

// File: rtl/fseq_line_counter.sv
module fseq_line_counter #(
  parameter int unsigned LINES = 1214,
  parameter int unsigned LW    = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          adv,
  input  logic [LW-1:0] shut_line,
  output logic          last,
  output logic          shut_hit
);
  logic [LW-1:0] cnt_q;

  assign last     = (cnt_q == LW'(LINES - 1));
  assign shut_hit = (cnt_q == shut_line);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (adv)     cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  // R4: the readout count stays inside the frame
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q < LW'(LINES));

  // R9: the count only moves on an accepted line transfer
  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lt_done,
  input  logic       expire,
  input  logic       last_line,
  output logic       lt_req,
  output logic [2:0] lt_sel,
  output logic       integ_run,
  output logic       frame_valid,
  output logic       line_adv,
  output logic       cnt_clear
);
  fseq_state_t state_q;
  logic        req_q;
  logic        fv_q;
  logic        fv_d;
  logic        accept;
  logic        fv_fall;

  assign accept    = req_q && lt_done;
  assign fv_fall   = fv_d && !fv_q;
  assign lt_req    = req_q;
  assign integ_run = (state_q == ST_INTEG);
  assign frame_valid = fv_q;
  assign line_adv  = accept && (state_q == ST_READ);
  assign cnt_clear = (state_q == ST_INTEG);

  always_comb begin
    unique case (state_q)
      ST_DIODE: lt_sel = TBL_DIODE;
      ST_FLUSH: lt_sel = TBL_FLUSH;
      default:  lt_sel = TBL_LINE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_DIODE;
      req_q   <= 1'b0;
      fv_q    <= 1'b0;
      fv_d    <= 1'b0;
    end else begin
      fv_d <= fv_q;
      unique case (state_q)
        ST_DIODE: begin
          if (accept) begin
            req_q   <= 1'b0;
            state_q <= ST_INTEG;
          end else req_q <= 1'b1;
        end
        ST_INTEG: begin
          if (expire) begin
            state_q <= ST_READ;
            fv_q    <= 1'b1;
          end
        end
        ST_READ: begin
          if (accept) begin
            req_q <= 1'b0;
            if (last_line) begin
              fv_q    <= 1'b0;
              state_q <= ST_FVWAIT;
            end
          end else req_q <= 1'b1;
        end
        ST_FVWAIT: begin
          if (fv_fall) state_q <= ST_FLUSH;
        end
        ST_FLUSH: begin
          if (accept) begin
            req_q   <= 1'b0;
            state_q <= ST_DIODE;
          end else req_q <= 1'b1;
        end
        default: state_q <= ST_DIODE;
      endcase
    end
  end

  // R2: a pending request holds with a stable table code
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (lt_req && !lt_done) |=> (lt_req && $stable(lt_sel)));

  // R2: an accepted request drops for a cycle
  p_req_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (lt_req && lt_done) |=> !lt_req);

  // R4: exposure and readout never overlap
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    !(integ_run && frame_valid));

  // R5: the end of readout leads to the flush table
  p_flush_next_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(fv_q) |=> (state_q == ST_FLUSH));

  // R3: exposure ends only by counter expiry
  p_integ_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (integ_run && !expire) |=> integ_run);
endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq
  import fseq_pkg::*;
#(
  parameter int unsigned READOUT_LINES = 1214,
  parameter int unsigned INTEG_TICKS   = 1,
  parameter int unsigned SHUT_STEP     = 138,
  parameter int unsigned NO_SHUT_LINE  = 2040
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] preset_sel,
  input  logic       tick_ms,
  input  logic       lt_done,
  output logic       lt_req,
  output logic [2:0] lt_sel,
  output logic       integrate,
  output logic       frame_valid,
  output logic       shutter_pulse
);
  localparam int unsigned LW = $clog2(max2(READOUT_LINES, NO_SHUT_LINE) + 1);
  localparam int unsigned TW = (INTEG_TICKS > 1) ? $clog2(INTEG_TICKS) : 1;

  logic [2:0]    preset_q;
  logic [LW-1:0] shut_line;
  logic          expire;
  logic          last_line;
  logic          shut_hit;
  logic          line_adv;
  logic          cnt_clear;

  always_ff @(posedge clk) begin
    if (rst) preset_q <= preset_sel;
  end

  assign shut_line = LW'(shutter_line_of(preset_q, SHUT_STEP, NO_SHUT_LINE));

  fseq_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .lt_done     (lt_done),
    .expire      (expire),
    .last_line   (last_line),
    .lt_req      (lt_req),
    .lt_sel      (lt_sel),
    .integ_run   (integrate),
    .frame_valid (frame_valid),
    .line_adv    (line_adv),
    .cnt_clear   (cnt_clear)
  );

  fseq_integ_timer #(.TICKS(INTEG_TICKS), .TW(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (integrate),
    .tick   (tick_ms),
    .expire (expire)
  );

  fseq_line_counter #(.LINES(READOUT_LINES), .LW(LW)) u_lines (
    .clk       (clk),
    .rst       (rst),
    .clear     (cnt_clear),
    .adv       (line_adv),
    .shut_line (shut_line),
    .last      (last_line),
    .shut_hit  (shut_hit)
  );

  assign shutter_pulse = frame_valid && shut_hit;

  // R8: the preset register moves only under reset
  p_preset_hold_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(preset_q));

  // R7: the pulse lasts until the next accepted line transfer
  p_shut_stay_r7: assert property (@(posedge clk) disable iff (rst)
    (shutter_pulse && !line_adv) |=> shutter_pulse);

  // R7: the pulse covers a single line
  p_shut_end_r7: assert property (@(posedge clk) disable iff (rst)
    (shutter_pulse && line_adv) |=> !shutter_pulse);

  // R7: no pulse outside readout
  p_shut_in_read_r7: assert property (@(posedge clk) disable iff (rst)
    shutter_pulse |-> frame_valid);
endmodule

// File: tb/ccd_frame_seq_test.sv
module ccd_frame_seq_test;
  localparam int unsigned LINES = 20;
  localparam int unsigned TICKS = 3;
  localparam int unsigned STEP  = 2;
  localparam int unsigned NONE  = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] preset_sel = 3'd0;
  logic       tick_ms = 1'b0;
  logic       lt_done = 1'b0;
  logic       lt_req;
  logic [2:0] lt_sel;
  logic       integrate;
  logic       frame_valid;
  logic       shutter_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ccd_frame_seq #(.READOUT_LINES(LINES), .INTEG_TICKS(TICKS),
                  .SHUT_STEP(STEP), .NO_SHUT_LINE(NONE)) uut (
    .clk(clk), .rst(rst), .preset_sel(preset_sel), .tick_ms(tick_ms),
    .lt_done(lt_done), .lt_req(lt_req), .lt_sel(lt_sel),
    .integrate(integrate), .frame_valid(frame_valid),
    .shutter_pulse(shutter_pulse));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_line(input int idx);
    if (idx == 0) return NONE;
    return STEP * (8 - idx);
  endfunction

  task automatic wait_req(input string tag);
    int n = 0;
    while (!lt_req && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(lt_req, {tag, " request seen"}, lt_req, 1);
  endtask

  // One handshake: hold, accept, drop. extra keeps done high in the gap (R9).
  task automatic serve(input int sel, input string tag, input bit extra);
    wait_req(tag);
    check(lt_sel == 3'(sel), {tag, " table code"}, lt_sel, sel);
    @(negedge clk);
    check(lt_req && lt_sel == 3'(sel), "R2 request held", lt_req, 1);
    lt_done = 1'b1;
    @(negedge clk);
    check(!lt_req, "R2 request dropped", lt_req, 0);
    if (extra) begin
      tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0;
    end
    lt_done = 1'b0;
  endtask

  task automatic do_reset(input logic [2:0] p);
    rst = 1'b1;
    preset_sel = p;
    repeat (3) @(negedge clk);
    check(!lt_req && !integrate && !frame_valid && !shutter_pulse,
          "R1 outputs low in reset", {lt_req, integrate, frame_valid, shutter_pulse}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!integrate && !frame_valid && !shutter_pulse,
          "R1 outputs low after reset", {integrate, frame_valid, shutter_pulse}, 0);
  endtask

  task automatic run_frame(input int shut, input bit noise);
    if (noise) begin
      tick_ms = 1'b1;                      // R9: ticks before exposure
      @(negedge clk);
      tick_ms = 1'b0;
    end
    serve(1, "R1 diode transfer", 1'b0);
    check(integrate && !frame_valid, "R3 integrate rises", integrate, 1);
    for (int k = 0; k < int'(TICKS); k++) begin
      @(negedge clk);
      tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0;
      if (k < int'(TICKS) - 1)
        check(integrate, "R3 integrate held", integrate, 1);
      else
        check(!integrate && frame_valid, "R4 readout begins", {integrate, frame_valid}, 1);
    end
    for (int n = 0; n < int'(LINES); n++) begin
      wait_req("R4 line transfer");
      check(lt_sel == 3'd0, "R4 line table code", lt_sel, 0);
      check(frame_valid, "R4 frame_valid during readout", frame_valid, 1);
      check(shutter_pulse == (n == shut), "R7 shutter position", shutter_pulse, (n == shut));
      serve(0, "R4 line transfer", noise && (n == 5));
    end
    check(!frame_valid && !shutter_pulse, "R4 frame_valid falls", frame_valid, 0);
    serve(5, "R5 flush", 1'b0);
    wait_req("R5 restart");
    check(lt_sel == 3'd1, "R5 restart with diode transfer", lt_sel, 1);
  endtask

  task automatic test_preset_hold;
    do_reset(3'd3);
    preset_sel = 3'd7;                     // R8: ignored after reset
    run_frame(exp_line(3), 1'b0);
    run_frame(exp_line(3), 1'b0);
  endtask

  task automatic test_presets;
    do_reset(3'd0);                        // R6: no pulse
    run_frame(-1, 1'b0);
    do_reset(3'd7);                        // R6: line STEP*1
    run_frame(exp_line(7), 1'b1);
    do_reset(3'd1);                        // R6: line STEP*7
    run_frame(exp_line(1), 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    test_preset_hold();
    test_presets();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule